// File: doc/BRIEF.md
# Modem Line Controller

This block handles the modem side-band lines of a serial port. Four incoming lines (clear-to-send, carrier detect, ring indicator and data-set-ready) pass through a synchronizer. Their present levels can be read at any time. A transition in either direction on clear-to-send or carrier detect latches a per-line event flag, but only when that line's event mask is set. The flags are ORed into one summary interrupt, which has its own enable bit.

On the output side, the block drives the data-terminal-ready and request-to-send pins and a loopback enable for the neighbouring datapath. Each pin drives the inverse of the bit written for it. Software reaches the block through two registers: a line-status register, selected with `reg_sel` = 0, and a modem-control register, selected with `reg_sel` = 1. A read strobe on the line-status register clears the event flags. An event that arrives in the same cycle as that read stays pending, so none is lost.

Top module: `modem_line_ctl`

## Requirements
- R1: After a synchronous reset the event flags, masks, no-sense bits and control bits are all zero. The `dtr_o` and `rts_o` pins are therefore 1, and `loop_en_o` and `irq_o` are 0.
- R2: The line-status register (`reg_sel` = 0) returns the line levels in bits [3:0]: bit0 clear-to-send, bit1 carrier detect, bit2 data-set-ready, bit3 ring indicator. A level change on an input appears there after exactly two clock edges.
- R3: A rising or a falling transition sets an event flag: clear-to-send sets bit4, gated by mask bit6, and carrier detect sets bit5, gated by mask bit7. The flag is visible three clock edges after the input changes and stays set until it is cleared.
- R4: A transition on a line whose mask bit is 0 leaves that line's event flag at 0.
- R5: Transitions on ring indicator or data-set-ready never set an event flag.
- R6: A read strobe (`reg_rd` with `reg_sel` = 0) returns the flags as they stand in that cycle and clears them at that clock edge.
- R7: A masked-in transition that is detected in the same cycle as a clearing read leaves its flag set after that edge.
- R8: The modem-control register (`reg_sel` = 1) holds data-terminal-ready in bit0, request-to-send in bit1, loopback in bit2 and summary-interrupt enable in bit3, and it reads back in bits [3:0]. One clock edge after a write, `dtr_o` equals the inverse of bit0, `rts_o` the inverse of bit1, and `loop_en_o` equals bit2.
- R9: `irq_o` is 1 exactly when the summary enable is 1 and at least one event flag is set.
- R10: No-sense bits for clear-to-send (bit8) and carrier detect (bit9) of the line-status register are written and read back, and they do not change event detection.
- R11: A write to the line-status register updates only the masks and no-sense bits; the event flags cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dcd_i | input | 1 | Carrier-detect line, asynchronous |
| ri_i | input | 1 | Ring-indicator line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| reg_sel | input | 1 | Register select: 0 line-status, 1 modem-control |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, clears event flags when `reg_sel` = 0 |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 10 | Read data of the selected register |
| dtr_o | output | 1 | Data-terminal-ready pin, inverse of control bit0 |
| rts_o | output | 1 | Request-to-send pin, inverse of control bit1 |
| loop_en_o | output | 1 | Loopback enable |
| irq_o | output | 1 | Summary modem-status interrupt |

## Verification
The hardest case to reach is a transition whose detection falls in the very cycle of a clearing read, because the synchronizer adds delay between the pin and the detector. The stimulus changes clear-to-send on a falling clock edge, waits two full cycles so that the detector sees the change, and then raises the read strobe for exactly that one cycle. It then checks that the flag is still set. Both edge directions and both masked lines are driven, along with the unmasked and never-sensed lines, so that each gating path is observed at the register port.

// File: rtl/modem_line_pkg.sv
package modem_line_pkg;

    localparam int REG_W      = 10;
    localparam int NUM_LINES  = 4;
    localparam int NUM_EVENTS = 2;
    localparam int CTL_W      = 4;

    localparam logic SEL_LINE = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    // bit0 cts, bit1 dcd, bit2 dsr, bit3 ri
    typedef struct packed {
        logic ri;
        logic dsr;
        logic dcd;
        logic cts;
    } line_t;

    // bit0 dtr, bit1 rts, bit2 loopback, bit3 summary enable
    typedef struct packed {
        logic irq_en;
        logic loop_en;
        logic rts;
        logic dtr;
    } mctl_t;

    typedef struct packed {
        logic [NUM_EVENTS-1:0] nosense;
        logic [NUM_EVENTS-1:0] mask;
    } evcfg_t;

    function automatic logic [REG_W-1:0] pack_line_word(
        input line_t                 lv,
        input logic [NUM_EVENTS-1:0] flags,
        input evcfg_t                cfg
    );
        return {cfg.nosense, cfg.mask, flags, lv};
    endfunction

endpackage

// File: rtl/mlc_sync.sv
module mlc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage[k] <= '0;
        end else begin
            stage[0] <= d;
            for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/mlc_edge_latch.sv
module mlc_edge_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level,
    input  logic [N-1:0] mask,
    input  logic         clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] prev;
    logic [N-1:0] hit;

    assign hit = (level ^ prev) & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= '0;
            flags <= '0;
        end else begin
            prev  <= level;
            flags <= (flags & ~{N{clr}}) | hit;
        end
    end

    // Flags are sticky without a clearing read
    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    // A clearing read with no fresh event leaves every flag at zero
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && (((level ^ prev) & mask) == '0)) |=> (flags == '0));

    // An event in the clearing cycle survives
    assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && (((level ^ prev) & mask) != '0))
        |=> ((flags & $past((level ^ prev) & mask)) == $past((level ^ prev) & mask)));

    // A flag never newly rises on a line that was masked off
    assert_masked_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(mask)) == '0));
endmodule

// File: rtl/mlc_cfg_regs.sv
module mlc_cfg_regs
    import modem_line_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_line,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wdata,
    output evcfg_t           evcfg,
    output mctl_t            ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evcfg <= '0;
            ctl   <= '0;
        end else begin
            if (wr_line) evcfg <= wdata[REG_W-1:NUM_LINES+NUM_EVENTS];
            if (wr_ctrl) ctl   <= wdata[CTL_W-1:0];
        end
    end
endmodule

// File: rtl/modem_line_ctl.sv
module modem_line_ctl
    import modem_line_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cts_i,
    input  logic             dcd_i,
    input  logic             ri_i,
    input  logic             dsr_i,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             dtr_o,
    output logic             rts_o,
    output logic             loop_en_o,
    output logic             irq_o
);
    line_t                 raw_lines;
    line_t                 sync_lines;
    evcfg_t                evcfg;
    mctl_t                 ctl;
    logic [NUM_EVENTS-1:0] flags;
    logic                  clr_flags;

    assign raw_lines = '{ri: ri_i, dsr: dsr_i, dcd: dcd_i, cts: cts_i};
    assign clr_flags = reg_rd && (reg_sel == SEL_LINE);

    mlc_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    mlc_edge_latch #(.N(NUM_EVENTS)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .level ({sync_lines.dcd, sync_lines.cts}),
        .mask  (evcfg.mask),
        .clr   (clr_flags),
        .flags (flags)
    );

    mlc_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_line (reg_wr && (reg_sel == SEL_LINE)),
        .wr_ctrl (reg_wr && (reg_sel == SEL_CTRL)),
        .wdata   (reg_wdata),
        .evcfg   (evcfg),
        .ctl     (ctl)
    );

    always_comb begin
        if (reg_sel == SEL_LINE) reg_rdata = pack_line_word(sync_lines, flags, evcfg);
        else                     reg_rdata = {{(REG_W-CTL_W){1'b0}}, ctl};
    end

    assign dtr_o     = ~ctl.dtr;
    assign rts_o     = ~ctl.rts;
    assign loop_en_o = ctl.loop_en;
    assign irq_o     = ctl.irq_en && (|flags);

    // Pins follow the inverse of the written control word one edge later
    assert_pin_inv_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == SEL_CTRL)
        |=> (dtr_o == !$past(reg_wdata[0]) && rts_o == !$past(reg_wdata[1])
             && loop_en_o == $past(reg_wdata[2])));

    // Summary interrupt silent while disabled by the last control write
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == SEL_CTRL && !reg_wdata[3]) |=> !irq_o);
endmodule

// File: tb/modem_line_ctl_bench.sv
module modem_line_ctl_bench;
    import modem_line_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cts_i = 0, dcd_i = 0, ri_i = 0, dsr_i = 0;
    logic reg_sel = 0, reg_wr = 0, reg_rd = 0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic dtr_o, rts_o, loop_en_o, irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    modem_line_ctl u_modem_line_ctl (
        .clk(clk), .rst(rst), .cts_i(cts_i), .dcd_i(dcd_i), .ri_i(ri_i), .dsr_i(dsr_i),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dtr_o(dtr_o), .rts_o(rts_o), .loop_en_o(loop_en_o),
        .irq_o(irq_o)
    );

    // control word [3:0], expected {dtr, rts, loop}
    localparam logic [6:0] VEC [6] = '{
        7'b0000_110, 7'b0001_010, 7'b0010_100,
        7'b0011_000, 7'b0100_111, 7'b0111_001
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [REG_W-1:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1;
        step(1);
        reg_wr = 0;
    endtask

    task automatic peek(output logic [REG_W-1:0] d);
        reg_sel = SEL_LINE; #1; d = reg_rdata;
    endtask

    task automatic rd_clear(output logic [REG_W-1:0] d);
        reg_sel = SEL_LINE; reg_rd = 1; #1; d = reg_rdata;
        step(1);
        reg_rd = 0;
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [REG_W-1:0] d;
        step(3);
        rst = 0;
        step(1);
        // R1 reset state
        check("R1 pins", {dtr_o, rts_o, loop_en_o, irq_o}, 4'b1100);
        peek(d); check("R1 line word", d, 0);

        // R8 vector table of control writes
        foreach (VEC[i]) begin
            wr(SEL_CTRL, {6'b0, VEC[i][6:3]});
            check("R8 pins", {dtr_o, rts_o, loop_en_o}, VEC[i][2:0]);
            reg_sel = SEL_CTRL; #1;
            check("R8 readback", reg_rdata, {6'b0, VEC[i][6:3]});
        end
        wr(SEL_CTRL, 10'h000);

        // R2 levels with two-edge latency; R4 masks still off
        cts_i = 1; ri_i = 1;
        step(1); peek(d); check("R2 not yet", d[3:0], 4'b0000);
        step(1); peek(d); check("R2 levels", d[3:0], 4'b1001);
        step(2); peek(d); check("R4 unmasked edge", d[5:4], 2'b00);

        // R11/R10 write masks, no-sense, attempt flags
        wr(SEL_LINE, {2'b10, 2'b11, 2'b11, 4'b1111});
        peek(d); check("R10 readback", d[9:6], 4'b1011);
        check("R11 flags not writable", d[5:4], 2'b00);

        // R3 falling edge on cts
        cts_i = 0;
        step(2); peek(d); check("R3 not yet", d[5:4], 2'b00);
        step(1); peek(d); check("R3 cts fall", d[5:4], 2'b01);
        check("R9 disabled", irq_o, 0);
        wr(SEL_CTRL, 10'b1000);
        check("R9 enabled", irq_o, 1);
        step(3); peek(d); check("R3 sticky", d[5:4], 2'b01);

        // R6 clearing read
        rd_clear(d); check("R6 returned", d[5:4], 2'b01);
        peek(d); check("R6 cleared", d[5:4], 2'b00);
        check("R9 after clear", irq_o, 0);

        // R3/R10 rising dcd with its no-sense bit set
        dcd_i = 1; step(3); peek(d); check("R10 dcd rise", d[5:4], 2'b10);
        rd_clear(d);

        // R5 ri and dsr never flag
        ri_i = 0; dsr_i = 1; step(4); peek(d);
        check("R5 no flag", d[5:4], 2'b00);
        check("R2 dsr level", d[3:0], 4'b0110);

        // R7 event coincident with clearing read
        cts_i = 1; step(2);
        rd_clear(d);
        peek(d); check("R7 kept", d[5:4], 2'b01);
        check("R7 irq", irq_o, 1);
        rd_clear(d);
        peek(d); check("R7 then cleared", d[5:4], 2'b00);

        // R4 dcd masked off
        wr(SEL_LINE, {2'b00, 2'b01, 6'b0});
        dcd_i = 0; step(4); peek(d);
        check("R4 dcd masked", d[5:4], 2'b00);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule